// File: doc/BRIEF.md
# Power Management Event Register Block

This block holds the fixed power-management registers of a platform: a 16-bit event status word, a 16-bit event enable word, a 16-bit control word and a free-running power-management timer. Software reaches them through a small I/O-port interface made of an address, byte enables, a read strobe and a write strobe. Status bits are set by hardware events and cleared by writing ones. The block drives a level-sensitive system control interrupt (SCI) whenever an enabled interrupt source has its status bit set.

A write to the control word with the sleep-enable bit set is decoded by its sleep-type field. The block then emits a one-cycle power-off request or a one-cycle reset request to platform logic outside the block. Before the reset request it marks the resume and power-button status bits. A power-button event input either raises the button status bit or, while the SCI enable is off, asks directly for power-off. The timer advances on a clock-enable tick that the platform supplies at the timer rate, nominally 3.579545 MHz. Bit 0 of the control word can also be driven through two one-cycle side-band inputs.

Top module: `pm_evt_top`

## Requirements
- R1: After reset, status, enable, control and timer all read as zero, and `sciOut`, `offReq` and `rstReq` are low.
- R2: Only `ioAddr` modulo 64 is decoded. Offset 0x00 is status, 0x02 is enable and 0x04 is control, each 16 bits wide and right-justified in `ioRdata`/`ioWdata`. Offset 0x08 returns the timer in the low `TMR_W` bits with the upper bits zero. A read at any other offset returns zero. Writes to any other offset, or to 0x08, change no register.
- R3: On a write to a 16-bit register, `ioBe[0]` gates bits 7:0 and `ioBe[1]` gates bits 15:8. A byte lane that is not enabled keeps its old value.
- R4: A write to status clears every bit written as 1 in an enabled lane. Bits written as 0 keep their value.
- R5: The timer increments by exactly one on each cycle with `tmrTick` high and holds otherwise. It wraps from all-ones to zero.
- R6: Status bit 0 is set on every tick that changes the timer's most significant bit, both on the 0-to-1 change and on the wrap.
- R7: `sciOut` is high exactly when status AND enable is non-zero in bit 10, 8, 5 or 0. Other status bits never raise it.
- R8: Control bit 13 is never stored and always reads 0. A sleep command is acted on only when bit 13 is written as 1 with `ioBe[1]` high. The command type is taken from bits 12:10.
- R9: Sleep type 0 makes `offReq` high for exactly the one cycle after the write edge.
- R10: Sleep type 1 sets status bits 15 and 8 and makes `rstReq` high for exactly one cycle. Sleep types 2 to 7 produce no request pulse.
- R11: A `pwrBtnEvt` pulse sets status bit 8 when control bit 0 and enable bit 8 are both 1. When control bit 0 is 0, the pulse gives a one-cycle `offReq` and leaves status unchanged. With control bit 0 set but enable bit 8 clear, the pulse has no effect.
- R12: A `sciEnSet` pulse sets control bit 0 and a `sciEnClr` pulse clears it. If both are high in the same cycle, the bit is cleared.
- R13: A hardware set of a status bit in the same cycle as a software clear of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrTick | input | 1 | Timer-rate clock enable |
| ioAddr | input | ADDR_W | Port address (modulo 64 decoded) |
| ioBe | input | 4 | Byte enables |
| ioWr | input | 1 | Write strobe |
| ioRd | input | 1 | Read strobe |
| ioWdata | input | 32 | Write data, right-justified |
| ioRdata | output | 32 | Read data (combinational) |
| pwrBtnEvt | input | 1 | Power-button event pulse |
| sciEnSet | input | 1 | Side-band set of control bit 0 |
| sciEnClr | input | 1 | Side-band clear of control bit 0 |
| sciOut | output | 1 | Level system control interrupt |
| offReq | output | 1 | Power-off request pulse |
| rstReq | output | 1 | Reset request pulse |

## Verification
The register map is exercised with aliased addresses, unmapped offsets and single-lane writes. These show whether the decode ignores the upper address bits and whether each byte lane is gated on its own. The power button is pulsed under three states: SCI enable off, button enable off, and both on. Each state must give a different result: a power-off pulse, nothing, or a status bit. The sleep commands are written with type 0, type 1, type 2 and no sleep-enable bit, and with only the low lane enabled, to separate acting on the command from merely storing the control word. The timer is run up to just below and just past its top-bit change and its wrap, which catches an off-by-one in the overflow detection.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W  = 16;
  localparam int DATA_W = 32;

  localparam logic [5:0] OFF_STS = 6'h00;
  localparam logic [5:0] OFF_EN  = 6'h02;
  localparam logic [5:0] OFF_CTL = 6'h04;
  localparam logic [5:0] OFF_TMR = 6'h08;

  // Interrupt sources: bit 10, bit 8, bit 5, bit 0
  localparam logic [REG_W-1:0] SCI_SRC_MASK = 16'h0521;

  localparam int BIT_TOVF   = 0;
  localparam int BIT_BTN    = 8;
  localparam int BIT_RESUME = 15;
  localparam int BIT_SLPGO  = 13;
  localparam int BIT_SCIEN  = 0;

  typedef enum logic [2:0] {
    RS_NONE, RS_STS, RS_EN, RS_CTL, RS_TMR
  } rdsel_e;

  typedef struct packed {
    logic       wrSts;
    logic       wrEn;
    logic       wrCtl;
    logic       setResume;
    logic       setBtn;
    logic       sciSet;
    logic       sciClr;
    logic [1:0] laneEn;
    rdsel_e     rdSel;
  } pm_strobe_t;
endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [3:0]        ioBe,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [REG_W-1:0]  wrData,
  input  logic              pwrBtnEvt,
  input  logic              sciEnSet,
  input  logic              sciEnClr,
  input  logic              btnEnBit,
  input  logic              sciEnBit,
  output pm_strobe_t        st,
  output logic              offReq,
  output logic              rstReq
);
  logic [5:0] regOff;
  logic       sleepGo;
  logic [2:0] sleepType;
  logic       offNext;
  logic       rstNext;
  logic       unusedHiBits;

  assign regOff       = ioAddr[5:0];
  assign unusedHiBits = ^{ioAddr[ADDR_W-1:6], ioBe[3:2]};

  assign sleepGo   = ioWr && (regOff == OFF_CTL) && ioBe[1] && wrData[BIT_SLPGO];
  assign sleepType = wrData[12:10];

  always_comb begin
    st           = '0;
    st.wrSts     = ioWr && (regOff == OFF_STS);
    st.wrEn      = ioWr && (regOff == OFF_EN);
    st.wrCtl     = ioWr && (regOff == OFF_CTL);
    st.laneEn    = ioBe[1:0];
    st.setResume = sleepGo && (sleepType == 3'd1);
    st.setBtn    = pwrBtnEvt && sciEnBit && btnEnBit;
    st.sciSet    = sciEnSet;
    st.sciClr    = sciEnClr;
    st.rdSel     = RS_NONE;
    if (ioRd) begin
      case (regOff)
        OFF_STS: st.rdSel = RS_STS;
        OFF_EN:  st.rdSel = RS_EN;
        OFF_CTL: st.rdSel = RS_CTL;
        OFF_TMR: st.rdSel = RS_TMR;
        default: st.rdSel = RS_NONE;
      endcase
    end
  end

  assign offNext = (sleepGo && (sleepType == 3'd0)) || (pwrBtnEvt && !sciEnBit);
  assign rstNext = st.setResume;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReq <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      offReq <= offNext;
      rstReq <= rstNext;
    end
  end

  assert_rst_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> ($past(ioWr) && $past(ioBe[1]) && ($past(regOff) == OFF_CTL)
                && ($past(wrData[12:10]) == 3'd1) && $past(wrData[BIT_SLPGO])));

  assert_off_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    offReq |-> ($past(sleepGo) || ($past(pwrBtnEvt) && !$past(sciEnBit))));
endmodule

// File: rtl/pm_evt_datapath.sv
module pm_evt_datapath
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrTick,
  input  pm_strobe_t        st,
  input  logic [REG_W-1:0]  wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sciOut,
  output logic              btnEnBit,
  output logic              sciEnBit
);
  localparam int LOW_W = TMR_W - 1;

  logic [REG_W-1:0] stsReg, enReg, ctlReg;
  logic [REG_W-1:0] stsNext, ctlNext, laneMask;
  logic [TMR_W-1:0] tmrCnt;
  logic             tmrOvf;

  assign laneMask = {{8{st.laneEn[1]}}, {8{st.laneEn[0]}}};
  assign tmrOvf   = tmrTick && (&tmrCnt[LOW_W-1:0]);

  always_comb begin
    stsNext = stsReg;
    if (st.wrSts) stsNext = stsNext & ~(wrData & laneMask);
    if (tmrOvf)   stsNext[BIT_TOVF] = 1'b1;
    if (st.setBtn || st.setResume) stsNext[BIT_BTN] = 1'b1;
    if (st.setResume) stsNext[BIT_RESUME] = 1'b1;
  end

  always_comb begin
    ctlNext = ctlReg;
    if (st.wrCtl) ctlNext = (ctlReg & ~laneMask) | (wrData & laneMask);
    ctlNext[BIT_SLPGO] = 1'b0;
    if (st.sciClr)      ctlNext[BIT_SCIEN] = 1'b0;
    else if (st.sciSet) ctlNext[BIT_SCIEN] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stsReg <= '0;
      enReg  <= '0;
      ctlReg <= '0;
      tmrCnt <= '0;
    end else begin
      stsReg <= stsNext;
      ctlReg <= ctlNext;
      if (st.wrEn) enReg <= (enReg & ~laneMask) | (wrData & laneMask);
      if (tmrTick) tmrCnt <= tmrCnt + 1'b1;
    end
  end

  assign sciOut   = |(stsReg & enReg & SCI_SRC_MASK);
  assign btnEnBit = enReg[BIT_BTN];
  assign sciEnBit = ctlReg[BIT_SCIEN];

  always_comb begin
    case (st.rdSel)
      RS_STS:  rdData = DATA_W'(stsReg);
      RS_EN:   rdData = DATA_W'(enReg);
      RS_CTL:  rdData = DATA_W'(ctlReg);
      RS_TMR:  rdData = DATA_W'(tmrCnt);
      default: rdData = '0;
    endcase
  end

  assert_tmr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    tmrTick |=> (tmrCnt == $past(tmrCnt) + 1'b1));

  assert_tmr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !tmrTick |=> $stable(tmrCnt));

  assert_ovf_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tmrTick && (&tmrCnt[LOW_W-1:0])) |=> stsReg[BIT_TOVF]);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrSts && st.laneEn[1] && wrData[BIT_RESUME] && !st.setResume) |=> !stsReg[BIT_RESUME]);

  assert_sci_clr_R12: assert property (@(posedge clk) disable iff (!rstN)
    st.sciClr |=> !ctlReg[BIT_SCIEN]);

  assert_slp_bit_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.wrCtl |=> !ctlReg[BIT_SLPGO]);
endmodule

// File: rtl/pm_evt_top.sv
module pm_evt_top
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TMR_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrTick,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [3:0]        ioBe,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [31:0]       ioWdata,
  output logic [31:0]       ioRdata,
  input  logic              pwrBtnEvt,
  input  logic              sciEnSet,
  input  logic              sciEnClr,
  output logic              sciOut,
  output logic              offReq,
  output logic              rstReq
);
  pm_strobe_t       st;
  logic             btnEnBit, sciEnBit;
  logic [REG_W-1:0] wrData;
  logic             unusedWrHi;

  assign wrData     = ioWdata[REG_W-1:0];
  assign unusedWrHi = ^ioWdata[31:REG_W];

  pm_evt_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioBe(ioBe), .ioWr(ioWr), .ioRd(ioRd),
    .wrData(wrData), .pwrBtnEvt(pwrBtnEvt), .sciEnSet(sciEnSet), .sciEnClr(sciEnClr),
    .btnEnBit(btnEnBit), .sciEnBit(sciEnBit), .st(st), .offReq(offReq), .rstReq(rstReq)
  );

  pm_evt_datapath #(.TMR_W(TMR_W)) dp_i (
    .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .st(st), .wrData(wrData),
    .rdData(ioRdata), .sciOut(sciOut), .btnEnBit(btnEnBit), .sciEnBit(sciEnBit)
  );
endmodule

// File: tb/pm_evt_top_tb_top.sv
module pm_evt_top_tb_top;
  localparam int TW = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tmrTick = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [3:0]  ioBe = '0;
  logic        ioWr = 1'b0, ioRd = 1'b0;
  logic [31:0] ioWdata = '0;
  logic [31:0] ioRdata;
  logic        pwrBtnEvt = 1'b0, sciEnSet = 1'b0, sciEnClr = 1'b0;
  logic        sciOut, offReq, rstReq;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  pm_evt_top #(.ADDR_W(16), .TMR_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .tmrTick(tmrTick), .ioAddr(ioAddr), .ioBe(ioBe),
    .ioWr(ioWr), .ioRd(ioRd), .ioWdata(ioWdata), .ioRdata(ioRdata),
    .pwrBtnEvt(pwrBtnEvt), .sciEnSet(sciEnSet), .sciEnClr(sciEnClr),
    .sciOut(sciOut), .offReq(offReq), .rstReq(rstReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expectation for each read strobe
  always @(negedge clk) begin
    if (ioRd) begin
      if (expQ.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
      else check(tagQ.pop_front(), ioRdata, expQ.pop_front());
    end
  end

  task automatic doRead(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    ioAddr = a; ioRd = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #2;
    ioRd = 1'b0;
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [15:0] d, input logic [3:0] be,
                         input bit withBtn);
    @(posedge clk); #2;
    ioAddr = a; ioWdata = {16'hA5A5, d}; ioBe = be; ioWr = 1'b1; pwrBtnEvt = withBtn;
    @(posedge clk); #2;
    ioWr = 1'b0; pwrBtnEvt = 1'b0;
  endtask

  task automatic pulseIn(input bit btn, input bit sSet, input bit sClr);
    @(posedge clk); #2;
    pwrBtnEvt = btn; sciEnSet = sSet; sciEnClr = sClr;
    @(posedge clk); #2;
    pwrBtnEvt = 1'b0; sciEnSet = 1'b0; sciEnClr = 1'b0;
  endtask

  task automatic runTicks(input int n);
    @(posedge clk); #2;
    tmrTick = 1'b1;
    repeat (n) @(posedge clk);
    #2 tmrTick = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset state
    check("R1 sciOut", {31'd0, sciOut}, 0);
    check("R1 offReq", {31'd0, offReq}, 0);
    check("R1 rstReq", {31'd0, rstReq}, 0);
    doRead(16'h0000, 0, "R1 status");
    doRead(16'h0002, 0, "R1 enable");
    doRead(16'h0004, 0, "R1 control");
    doRead(16'h0008, 0, "R1 timer");

    // R2 aliasing, unmapped and timer writes
    doWrite(16'h0042, 16'h0121, 4'b0011, 0);
    doRead(16'h0002, 32'h0121, "R2 aliased enable write");
    doRead(16'h1C82, 32'h0121, "R2 aliased enable read");
    doRead(16'h0006, 0, "R2 unmapped read");
    doWrite(16'h0006, 16'hFFFF, 4'b1111, 0);
    doWrite(16'h0008, 16'hFFFF, 4'b1111, 0);
    doRead(16'h0000, 0, "R2 status after unmapped write");
    doRead(16'h0002, 32'h0121, "R2 enable after unmapped write");
    doRead(16'h0004, 0, "R2 control after unmapped write");
    doRead(16'h0008, 0, "R2 timer not writable");

    // R3 byte lanes
    doWrite(16'h0002, 16'hFFFF, 4'b0001, 0);
    doRead(16'h0002, 32'h01FF, "R3 low lane only");
    doWrite(16'h0002, 16'h0400, 4'b0010, 0);
    doRead(16'h0002, 32'h04FF, "R3 high lane only");
    doWrite(16'h0002, 16'h0000, 4'b0011, 0);

    // R12 side-band control bit 0
    pulseIn(0, 1, 0);
    doRead(16'h0004, 32'h0001, "R12 set");
    pulseIn(0, 1, 1);
    doRead(16'h0004, 32'h0000, "R12 clear wins");
    pulseIn(0, 1, 0);

    // R11 button with enable bit 8 clear: no effect
    pulseIn(1, 0, 0);
    check("R11 no offReq when SCI enabled", {31'd0, offReq}, 0);
    doRead(16'h0000, 0, "R11 ignored when enable bit 8 clear");
    doWrite(16'h0002, 16'h0100, 4'b0011, 0);
    pulseIn(1, 0, 0);
    doRead(16'h0000, 32'h0100, "R11 button sets status");
    check("R7 sci from button", {31'd0, sciOut}, 1);

    // R4 write-one-to-clear
    doWrite(16'h0000, 16'h0001, 4'b0011, 0);
    doRead(16'h0000, 32'h0100, "R4 zero bits untouched");
    doWrite(16'h0000, 16'h0100, 4'b0011, 0);
    doRead(16'h0000, 0, "R4 one bit cleared");
    check("R7 sci drops", {31'd0, sciOut}, 0);

    // R11 button while SCI enable off -> power-off pulse
    pulseIn(0, 0, 1);
    pulseIn(1, 0, 0);
    check("R11 offReq pulse", {31'd0, offReq}, 1);
    doRead(16'h0000, 0, "R11 status unchanged when disabled");
    check("R11 offReq one cycle", {31'd0, offReq}, 0);

    // R8/R9 sleep type 0
    doWrite(16'h0004, 16'h2001, 4'b0011, 0);
    check("R9 offReq pulse", {31'd0, offReq}, 1);
    check("R9 no rstReq", {31'd0, rstReq}, 0);
    doRead(16'h0004, 32'h0001, "R8 bit13 not stored");
    check("R9 offReq one cycle", {31'd0, offReq}, 0);
    doWrite(16'h0004, 16'h1C00, 4'b0011, 0);
    check("R8 no action without bit13", {31'd0, offReq | rstReq}, 0);
    doRead(16'h0004, 32'h1C00, "R8 type stored");
    doWrite(16'h0004, 16'h2000, 4'b0001, 0);
    check("R8 no action with high lane off", {31'd0, offReq | rstReq}, 0);
    doRead(16'h0004, 32'h1C00, "R8 low lane write");

    // R10 sleep type 1, R7 masking
    doWrite(16'h0002, 16'h8000, 4'b0011, 0);
    doWrite(16'h0004, 16'h2400, 4'b0011, 0);
    check("R10 rstReq pulse", {31'd0, rstReq}, 1);
    check("R10 no offReq", {31'd0, offReq}, 0);
    check("R7 bit15 not a source", {31'd0, sciOut}, 0);
    doRead(16'h0000, 32'h8100, "R10 resume and button status");
    check("R10 rstReq one cycle", {31'd0, rstReq}, 0);
    doWrite(16'h0002, 16'h0100, 4'b0011, 0);
    check("R7 enabled source", {31'd0, sciOut}, 1);
    doWrite(16'h0004, 16'h2800, 4'b0011, 0);
    check("R10 type 2 no pulse", {31'd0, offReq | rstReq}, 0);
    doWrite(16'h0000, 16'hFFFF, 4'b0011, 0);
    doRead(16'h0000, 0, "R4 clear all");

    // R13 set wins over same-cycle clear
    pulseIn(0, 1, 0);
    doWrite(16'h0000, 16'h0100, 4'b0011, 1);
    doRead(16'h0000, 32'h0100, "R13 set beats clear");
    doWrite(16'h0000, 16'h0100, 4'b0011, 0);

    // R5/R6 timer and overflow
    runTicks((1 << (TW-1)) - 1);
    doRead(16'h0008, (1 << (TW-1)) - 1, "R5 count below top bit");
    doRead(16'h0008, (1 << (TW-1)) - 1, "R5 holds without tick");
    doRead(16'h0000, 0, "R6 no early overflow");
    runTicks(1);
    doRead(16'h0008, 1 << (TW-1), "R5 top bit set");
    doRead(16'h0000, 32'h0001, "R6 overflow on rise");
    doWrite(16'h0002, 16'h0001, 4'b0011, 0);
    check("R7 timer source", {31'd0, sciOut}, 1);
    doWrite(16'h0000, 16'h0001, 4'b0011, 0);
    runTicks((1 << (TW-1)) - 1);
    doRead(16'h0008, (1 << TW) - 1, "R5 all ones");
    doRead(16'h0000, 0, "R6 no early wrap overflow");
    runTicks(1);
    doRead(16'h0008, 0, "R5 wrap");
    doRead(16'h0000, 32'h0001, "R6 overflow on wrap");

    repeat (3) @(posedge clk);
    #2 check("scoreboard drained", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule